// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition Flags

This block combines a combinational 32-bit arithmetic/logic datapath with a registered four-bit condition flag register. A 3-bit operation code selects one of the following:

- add
- subtract
- compare
- bitwise AND
- bitwise OR
- bitwise XOR
- pass-through of operand A

The block drives the result on `result` in the same cycle. A write strobe, `result_we`, tells the surrounding pipeline whether a destination register should capture that result.

The flag register keeps negative, zero, overflow and carry information for a later conditional branch unit. It loads on a rising clock edge only while `flag_we` is high.

The update depends on the class of operation:

- **Arithmetic operations** rewrite all four flags.
- **Logic operations** rewrite only negative and zero. Overflow and carry keep the values left by the last arithmetic operation.
- **Compare** behaves as a subtract for the flags, but it never raises the result strobe.

Top module: `alu_cc_top`

## Requirements
- R1: Op code 0 (add) drives `result` = A+B modulo 2^W, and `result_we` is 1. With `flag_we` high, the next edge loads C with the carry-out of the W-bit sum. The same edge sets V when A and B have equal sign bits and the sum's sign bit differs from A's.
- R2: Op code 1 (subtract) drives `result` = A−B modulo 2^W, and `result_we` is 1. With `flag_we` high, C becomes the carry-out of A + ~B + 1, which is 1 exactly when A ≥ B unsigned. V becomes 1 when the sign bits of A and B differ and the result's sign bit differs from A's.
- R3: Op code 2 (compare) loads all four flags exactly as subtract would, and holds `result_we` at 0.
- R4: Op codes 3, 4, 5 and 6 drive `result` = A AND B, A OR B, A XOR B and A respectively, with `result_we` at 1.
- R5: `flags` is laid out as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. For op codes 0–6 with `flag_we` high, the next rising edge sets N to bit W−1 of the result. The same edge sets Z to 1 when the W-bit result is zero and to 0 otherwise.
- R6: A logic op code (3–6) with `flag_we` high leaves V and C at their previous values.
- R7: While `flag_we` is low, `flags` keeps its value across clock edges, whatever the operation.
- R8: Op code 7 is reserved. It drives `result` to zero and `result_we` to 0, and leaves all flags unchanged even with `flag_we` high.
- R9: An asynchronous active-low `rst_n` clears `flags` to 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 compare, 3 and, 4 or, 5 xor, 6 pass A, 7 reserved) |
| flag_we | input | 1 | Flag register load enable |
| result | output | 32 | Combinational result |
| result_we | output | 1 | Result write strobe |
| flags | output | 4 | Registered flags {N, Z, V, C} |

## Verification
The bench builds the block with its default 32-bit width, so the sign, overflow and carry boundaries are the true word edges. Directed operands reach the cases random stimulus almost never produces:

- 32'h7FFFFFFF + 1, which overflows into the sign bit;
- 32'h80000000 − 1, which overflows out of it;
- all-ones + 1, which gives a carry with a zero result;
- equal operands in compare, which set Z and C.

Random operands, op codes and `flag_we` values then mix logic operations between arithmetic ones. This checks that V and C survive any run of logic operations and any cycle with `flag_we` low.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_PASS = 3'd6,
    OP_RSVD = 3'd7
  } alu_op_e;

  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FLG_N  = 3;
  localparam int unsigned FLG_Z  = 2;
  localparam int unsigned FLG_V  = 1;
  localparam int unsigned FLG_C  = 0;
endpackage

// File: rtl/alu_cc_arith.sv
module alu_cc_arith #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  localparam int unsigned XW = W + 1;

  // Full-width add with carry-in; the carry-out lands in the top bit.
  function automatic logic [XW-1:0] add_wide(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  // Signed overflow: equal input signs, differing output sign.
  function automatic logic sgn_ovf(input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

  logic [W-1:0]  b_eff;
  logic [XW-1:0] wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = add_wide(a, b_eff, sub);
    sum   = wide[W-1:0];
    carry = wide[W];
    ovf   = sgn_ovf(a[W-1], b_eff[W-1], wide[W-1]);
  end
endmodule

// File: rtl/alu_cc_logic.sv
module alu_cc_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]            a,
  input  logic [W-1:0]            b,
  input  alu_cc_pkg::alu_op_e     op,
  output logic [W-1:0]            y
);
  import alu_cc_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_PASS: y = a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg #(
  parameter int unsigned FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] d,
  output logic [FW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (load)
      q <= d;
  end
endmodule

// File: rtl/alu_cc_top.sv
module alu_cc_top #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   flags
);
  import alu_cc_pkg::*;

  alu_op_e      op;
  logic         op_is_arith;
  logic         op_is_sub;
  logic         op_is_logic;
  logic         op_known;
  logic         flag_upd;
  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic         arith_c;
  logic         arith_v;
  logic [FLAG_W-1:0] flags_d;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    op_is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    op_is_sub   = (op == OP_SUB) || (op == OP_CMP);
    op_is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_PASS);
    op_known    = op_is_arith || op_is_logic;
    flag_upd    = flag_we && op_known;
  end

  alu_cc_arith #(.W(W)) u_arith (
    .a(op_a), .b(op_b), .sub(op_is_sub),
    .sum(arith_y), .carry(arith_c), .ovf(arith_v)
  );

  alu_cc_logic #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .op(op), .y(logic_y)
  );

  always_comb begin
    result    = op_is_arith ? arith_y : logic_y;
    result_we = op_known && (op != OP_CMP);
    flags_d          = flags;
    flags_d[FLG_N]   = result[W-1];
    flags_d[FLG_Z]   = (result == '0);
    if (op_is_arith) begin
      flags_d[FLG_V] = arith_v;
      flags_d[FLG_C] = arith_c;
    end
  end

  alu_cc_flagreg #(.FW(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .load(flag_upd), .d(flags_d), .q(flags)
  );
endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op_sel,
  input logic         flag_we,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic [3:0]   flags,
  input logic         op_is_logic,
  input logic         op_known
);
  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));

  // R6
  logic_keeps_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_is_logic) |=> (flags[1:0] == $past(flags[1:0])));

  // R3
  cmp_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd2) |-> !result_we);

  // R8
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd7) |=> (flags == $past(flags)));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_known) |=> (flags[2] == ($past(result) == '0)));

  // R5
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_known) |=> (flags[3] == $past(result[W-1])));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags == 4'b0000));
endmodule

bind alu_cc_top alu_cc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .flag_we(flag_we),
  .result(result), .result_we(result_we), .flags(flags),
  .op_is_logic(op_is_logic), .op_known(op_known)
);

// File: tb/alu_cc_tb.sv
module alu_cc_top_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_r = '0, b_r = '0;
  logic [2:0]   op_r = 3'd0;
  logic         we_r = 1'b0;
  logic [W-1:0] result;
  logic         result_we;
  logic [3:0]   flags;

  int checks = 0;
  int failures = 0;
  logic [3:0] mflags = 4'b0000;

  always #2 clk = ~clk;

  alu_cc_top #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(a_r), .op_b(b_r), .op_sel(op_r),
    .flag_we(we_r), .result(result), .result_we(result_we), .flags(flags)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s;
  endfunction

  function automatic logic [W:0] ref_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s[W-1:0] = x - y;
    s[W]     = (x >= y);
    return s;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [2:0] op, input logic we);
    logic [W:0]   w;
    logic [W-1:0] er;
    logic         ewe, ev, ec, arith;
    string        tag;
    a_r = a; b_r = b; op_r = op; we_r = we;
    arith = (op <= 3'd2);
    ev = 1'b0; ec = 1'b0;
    case (op)
      3'd0: begin w = ref_add(a, b); er = w[W-1:0]; ec = w[W]; ewe = 1'b1;
                  ev = (a[W-1] == b[W-1]) && (er[W-1] != a[W-1]); tag = "R1"; end
      3'd1, 3'd2: begin w = ref_sub(a, b); er = w[W-1:0]; ec = w[W];
                  ewe = (op == 3'd1);
                  ev = (a[W-1] != b[W-1]) && (er[W-1] != a[W-1]);
                  tag = (op == 3'd1) ? "R2" : "R3"; end
      3'd3: begin er = a & b; ewe = 1'b1; tag = "R4"; end
      3'd4: begin er = a | b; ewe = 1'b1; tag = "R4"; end
      3'd5: begin er = a ^ b; ewe = 1'b1; tag = "R4"; end
      3'd6: begin er = a;     ewe = 1'b1; tag = "R4"; end
      default: begin er = '0; ewe = 1'b0; tag = "R8"; end
    endcase
    #1;
    check({tag, " result_we"}, {{(W-1){1'b0}}, result_we}, {{(W-1){1'b0}}, ewe});
    if (op != 3'd2) check({tag, " result"}, result, er);
    if (we && op != 3'd7) begin
      mflags[3] = er[W-1];
      mflags[2] = (er == '0);
      if (arith) begin mflags[1] = ev; mflags[0] = ec; end
    end
    @(negedge clk);
    check("R5 NZ", {{(W-2){1'b0}}, flags[3:2]}, {{(W-2){1'b0}}, mflags[3:2]});
    if (!we)            tag = "R7";
    else if (op == 3'd7) tag = "R8";
    else if (!arith)    tag = "R6";
    check({tag, " VC"}, {{(W-2){1'b0}}, flags[1:0]}, {{(W-2){1'b0}}, mflags[1:0]});
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    check("R9 reset flags", {{(W-4){1'b0}}, flags}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", {{(W-4){1'b0}}, flags}, '0);

    apply(32'h7FFFFFFF, 32'h1, 3'd0, 1'b1);          // R1 overflow
    apply(32'hFFFFFFFF, 32'h1, 3'd0, 1'b1);          // R1 carry, zero
    apply(32'h0F0F0000, 32'h0000F0F0, 3'd3, 1'b1);   // R6 logic keeps VC
    apply(32'h80000000, 32'h1, 3'd1, 1'b1);          // R2 overflow
    apply(32'h1, 32'h2, 3'd1, 1'b1);                 // R2 borrow
    apply(32'h1234, 32'h1234, 3'd2, 1'b1);           // R3 equal compare
    apply(32'hAAAA5555, 32'h0, 3'd6, 1'b1);          // R4 pass
    apply(32'hF0F0F0F0, 32'hFFFF0000, 3'd5, 1'b1);   // R4 xor
    apply(32'h0, 32'h0, 3'd4, 1'b1);                 // R4 or zero
    apply(32'h7FFFFFFF, 32'h7FFFFFFF, 3'd0, 1'b0);   // R7 no load
    apply(32'h5, 32'h9, 3'd7, 1'b1);                 // R8 reserved
    apply(32'h80000000, 32'h80000000, 3'd0, 1'b1);   // R1 carry+overflow zero
    apply(32'hFFFFFFFF, 32'h0, 3'd3, 1'b1);          // R6 after arith

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      logic [2:0]   ro;
      ra = $urandom();
      rb = (i % 9 == 0) ? ra : $urandom();
      ro = 3'($urandom_range(0, 7));
      apply(ra, rb, ro, ($urandom_range(0, 3) != 0));
    end

    rst_n = 1'b0;
    #1;
    check("R9 async reset", {{(W-4){1'b0}}, flags}, '0);
    mflags = 4'b0000;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule